// File: doc/BRIEF.md
# Sequential Endpoint Configuration Loader

This block holds the endpoint setup table of a USB function controller. Software writes the table as a byte stream to one register address. An internal pointer advances by one on every accepted byte and picks the destination slot. Each logical endpoint takes a five-byte record, and the table has room for ten records. Filling begins with byte 0 of logical endpoint 0. Once the last byte of the last record has been taken, the table is locked for the rest of the power cycle. Software can also lock a shorter table with a one-cycle done strobe.

The first byte of each record is a header that carries three fields: the endpoint number, the configuration number and the interface number. The fields are range-checked on arrival. Any violation sets a sticky error flag, but the byte is still stored and the pointer still advances, so the records after it stay aligned. The other four bytes of each record are kept raw.

A combinational lookup port takes a logical endpoint index. It returns a valid bit, the decoded header fields and the four raw bytes of that record.

Top module: `ep_cfg_loader`

## Requirements
- R1: A write is accepted when `wr_en_i` is high at a rising clock edge while the table is unlocked. The k-th accepted byte since reset (k counted from 0) is stored as byte k mod 5 of record k div 5. On the lookup port, `lkp_raw_o[7:0]` returns record byte 1, `[15:8]` byte 2, `[23:16]` byte 3 and `[31:24]` byte 4.
- R2: Byte 0 of a record is its header, decoded on the lookup port as follows: bits 7:4 give `lkp_ep_num_o`, bits 3:2 give `lkp_cfg_num_o` and bits 1:0 give `lkp_if_num_o`.
- R3: `lkp_valid_o` is 1 only when the index is below 10 and all five bytes of that record have been accepted. Once set, it stays set until reset.
- R4: The edge that accepts the 50th byte sets both `loaded_o` and `locked_o`. Before that edge, `loaded_o` is 0.
- R5: A write while `locked_o` is 1 changes no table byte, valid bit or pointer, and it sets `err_o`.
- R6: A header byte with an endpoint number above 3 or a configuration number above 1 sets `err_o`. That byte is still stored and the pointer still advances, so the next record lands in its proper slot.
- R7: A `cfg_done_i` pulse sets `locked_o` from the next edge on and leaves `loaded_o` at 0. Records that are not yet complete stay invalid.
- R8: `err_o` stays set once raised. Reset (`rst_ni` low) clears the table, the valid bits, the pointer, `loaded_o`, `locked_o` and `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Byte write strobe to the configuration address |
| wr_data_i | input | 8 | Written byte |
| cfg_done_i | input | 1 | Forces the lock before the table is full |
| lkp_idx_i | input | 4 | Logical endpoint index to look up |
| lkp_valid_o | output | 1 | Record at the index is complete |
| lkp_ep_num_o | output | 4 | Decoded endpoint number |
| lkp_cfg_num_o | output | 2 | Decoded configuration number |
| lkp_if_num_o | output | 2 | Decoded interface number |
| lkp_raw_o | output | 32 | Raw record bytes 1 to 4 |
| loaded_o | output | 1 | All 50 bytes accepted |
| locked_o | output | 1 | Further writes are refused |
| err_o | output | 1 | Sticky error: a write after lock or a bad header field |

## Verification
The assertions check several properties on every cycle:
- the pointer never advances while locked;
- a loaded table is always locked;
- the error flag never drops;
- a write against the lock always raises the error flag;
- the done strobe always locks;
- a record's valid bit never clears;
- an out-of-range index never reports valid.

Other properties can only be shown by the bench scenarios, because they depend on the byte history:
- which byte lands in which slot;
- how the header is decoded;
- that record alignment survives a bad header;
- that a refused write leaves the stored contents unchanged.

// File: rtl/ep_cfg_pkg.sv
package ep_cfg_pkg;
  localparam int unsigned HDR_EP_MAX  = 3;
  localparam int unsigned HDR_CFG_MAX = 1;

  typedef struct packed {
    logic [3:0] ep;
    logic [1:0] cfg;
    logic [1:0] intf;
  } ep_hdr_t;
endpackage

// File: rtl/ep_cfg_hdr_check.sv
module ep_cfg_hdr_check
  import ep_cfg_pkg::*;
(
  input  logic [7:0] byte_i,
  output ep_hdr_t    hdr_o,
  output logic       bad_o
);
  always_comb begin
    hdr_o = ep_hdr_t'(byte_i);
    bad_o = (32'(hdr_o.ep) > HDR_EP_MAX) || (32'(hdr_o.cfg) > HDR_CFG_MAX);
  end
endmodule

// File: rtl/ep_cfg_wr_ptr.sv
module ep_cfg_wr_ptr #(
  parameter  int N_EP      = 10,
  parameter  int REC_BYTES = 5,
  localparam int RW        = $clog2(N_EP),
  localparam int BW        = $clog2(REC_BYTES)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          cfg_done_i,
  input  logic          hdr_bad_i,
  output logic          wr_acc_o,
  output logic [RW-1:0] rec_idx_o,
  output logic [BW-1:0] byte_idx_o,
  output logic          loaded_o,
  output logic          locked_o,
  output logic          err_o
);
  logic [RW-1:0] rec_q;
  logic [BW-1:0] byte_q;
  logic          loaded_q, locked_q, err_q;
  logic          last_byte, last_rec, err_set;

  assign wr_acc_o  = wr_en_i && !locked_q;
  assign last_byte = (byte_q == BW'(REC_BYTES - 1));
  assign last_rec  = (rec_q == RW'(N_EP - 1));
  assign err_set   = (wr_en_i && locked_q) || (wr_acc_o && (byte_q == '0) && hdr_bad_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_q    <= '0;
      byte_q   <= '0;
      loaded_q <= 1'b0;
      locked_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (wr_acc_o) begin
        if (last_byte) begin
          byte_q <= '0;
          if (last_rec) begin
            loaded_q <= 1'b1;
            locked_q <= 1'b1;
          end else begin
            rec_q <= rec_q + RW'(1);
          end
        end else begin
          byte_q <= byte_q + BW'(1);
        end
      end
      if (cfg_done_i) locked_q <= 1'b1;
      if (err_set)    err_q    <= 1'b1;
    end
  end

  assign rec_idx_o  = rec_q;
  assign byte_idx_o = byte_q;
  assign loaded_o   = loaded_q;
  assign locked_o   = locked_q;
  assign err_o      = err_q;

  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(byte_q) < REC_BYTES) && (32'(rec_q) < N_EP)); // R1
  AST_NO_ADV_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    locked_q |=> ($stable(rec_q) && $stable(byte_q))); // R5
endmodule

// File: rtl/ep_cfg_rec_store.sv
module ep_cfg_rec_store #(
  parameter  int N_EP      = 10,
  parameter  int REC_BYTES = 5,
  parameter  int DW        = 8,
  localparam int RW        = $clog2(N_EP),
  localparam int BW        = $clog2(REC_BYTES),
  localparam int RAW_W     = (REC_BYTES - 1) * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_acc_i,
  input  logic [RW-1:0]    rec_idx_i,
  input  logic [BW-1:0]    byte_idx_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [RW-1:0]    lkp_idx_i,
  output logic             lkp_valid_o,
  output logic [DW-1:0]    lkp_hdr_o,
  output logic [RAW_W-1:0] lkp_raw_o
);
  logic [DW-1:0] mem_q [N_EP][REC_BYTES];
  logic          vld_q [N_EP];
  logic          in_range;
  logic [RW-1:0] sel;

  for (genvar r = 0; r < N_EP; r++) begin : g_rec
    logic hit_rec;
    assign hit_rec = wr_acc_i && (rec_idx_i == RW'(r));

    for (genvar b = 0; b < REC_BYTES; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                                 mem_q[r][b] <= '0;
        else if (hit_rec && byte_idx_i == BW'(b))   mem_q[r][b] <= wr_data_i;
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                            vld_q[r] <= 1'b0;
      else if (hit_rec && byte_idx_i == BW'(REC_BYTES - 1))   vld_q[r] <= 1'b1;
    end

    AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      vld_q[r] |=> vld_q[r]); // R3
  end

  assign in_range = (32'(lkp_idx_i) < N_EP);
  assign sel      = in_range ? lkp_idx_i : '0;

  assign lkp_valid_o = in_range && vld_q[sel];
  assign lkp_hdr_o   = mem_q[sel][0];

  for (genvar b = 1; b < REC_BYTES; b++) begin : g_raw
    assign lkp_raw_o[(b-1)*DW +: DW] = mem_q[sel][b];
  end
endmodule

// File: rtl/ep_cfg_loader.sv
module ep_cfg_loader
  import ep_cfg_pkg::*;
#(
  parameter  int N_EP      = 10,
  parameter  int REC_BYTES = 5,
  parameter  int DW        = 8,
  localparam int RW        = $clog2(N_EP),
  localparam int BW        = $clog2(REC_BYTES),
  localparam int RAW_W     = (REC_BYTES - 1) * DW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             cfg_done_i,
  input  logic [RW-1:0]    lkp_idx_i,
  output logic             lkp_valid_o,
  output logic [3:0]       lkp_ep_num_o,
  output logic [1:0]       lkp_cfg_num_o,
  output logic [1:0]       lkp_if_num_o,
  output logic [RAW_W-1:0] lkp_raw_o,
  output logic             loaded_o,
  output logic             locked_o,
  output logic             err_o
);
  ep_hdr_t       wr_hdr, lkp_hdr;
  logic          wr_bad;
  logic          wr_acc;
  logic [RW-1:0] rec_idx;
  logic [BW-1:0] byte_idx;
  logic [DW-1:0] lkp_hdr_byte;

  ep_cfg_hdr_check u_chk (
    .byte_i (wr_data_i[7:0]),
    .hdr_o  (wr_hdr),
    .bad_o  (wr_bad)
  );

  ep_cfg_wr_ptr #(.N_EP(N_EP), .REC_BYTES(REC_BYTES)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .cfg_done_i (cfg_done_i),
    .hdr_bad_i  (wr_bad),
    .wr_acc_o   (wr_acc),
    .rec_idx_o  (rec_idx),
    .byte_idx_o (byte_idx),
    .loaded_o   (loaded_o),
    .locked_o   (locked_o),
    .err_o      (err_o)
  );

  ep_cfg_rec_store #(.N_EP(N_EP), .REC_BYTES(REC_BYTES), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_acc_i    (wr_acc),
    .rec_idx_i   (rec_idx),
    .byte_idx_i  (byte_idx),
    .wr_data_i   (wr_data_i),
    .lkp_idx_i   (lkp_idx_i),
    .lkp_valid_o (lkp_valid_o),
    .lkp_hdr_o   (lkp_hdr_byte),
    .lkp_raw_o   (lkp_raw_o)
  );

  assign lkp_hdr       = ep_hdr_t'(lkp_hdr_byte[7:0]);
  assign lkp_ep_num_o  = lkp_hdr.ep;
  assign lkp_cfg_num_o = lkp_hdr.cfg;
  assign lkp_if_num_o  = lkp_hdr.intf;

  AST_LOCK_WRITE_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && locked_o) |=> err_o); // R5
  AST_LOADED_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loaded_o |-> locked_o); // R4
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o); // R8
  AST_DONE_LOCKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_done_i |=> locked_o); // R7
  AST_LKP_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(lkp_idx_i) >= N_EP) |-> !lkp_valid_o); // R3
endmodule

// File: tb/sim_ep_cfg_loader.sv
`timescale 1ns/100ps
module sim_ep_cfg_loader;
  localparam int N_EP = 10;
  localparam int REC  = 5;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = '0;
  logic        cfg_done = 1'b0;
  logic [3:0]  lkp_idx = '0;
  logic        lkp_valid;
  logic [3:0]  lkp_ep;
  logic [1:0]  lkp_cfg, lkp_if;
  logic [31:0] lkp_raw;
  logic        loaded, locked, err;

  always #2.5 clk = ~clk;

  ep_cfg_loader u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .cfg_done_i(cfg_done), .lkp_idx_i(lkp_idx), .lkp_valid_o(lkp_valid),
    .lkp_ep_num_o(lkp_ep), .lkp_cfg_num_o(lkp_cfg), .lkp_if_num_o(lkp_if),
    .lkp_raw_o(lkp_raw), .loaded_o(loaded), .locked_o(locked), .err_o(err)
  );

  typedef struct {
    int          idx;
    logic        vld;
    logic [7:0]  hdr;
    logic [31:0] raw;
    string       req;
  } item_t;

  item_t q[$];
  int errors = 0, checks = 0;

  logic [7:0] m_mem [N_EP][REC];
  bit         m_vld [N_EP];
  int         m_ptr;
  bit         m_lock, m_loaded, m_err;

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] raw_pat(input int r, input int b);
    return 8'(r * 37 + b * 11 + 5);
  endfunction

  function automatic logic [7:0] hdr_pat(input int r);
    return {4'(r % 4), 2'(r % 2), 2'((r + 1) % 4)};
  endfunction

  task automatic model_clear();
    for (int r = 0; r < N_EP; r++) begin
      m_vld[r] = 1'b0;
      for (int b = 0; b < REC; b++) m_mem[r][b] = '0;
    end
    m_ptr = 0; m_lock = 0; m_loaded = 0; m_err = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wr_en = 1'b0; cfg_done = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    model_clear();
  endtask

  task automatic wr_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
    if (!m_lock) begin
      int r, b;
      r = m_ptr / REC; b = m_ptr % REC;
      m_mem[r][b] = d;
      if (b == 0 && (d[7:4] > 4'd3 || d[3:2] > 2'd1)) m_err = 1;
      if (b == REC - 1) m_vld[r] = 1;
      m_ptr++;
      if (m_ptr == N_EP * REC) begin m_lock = 1; m_loaded = 1; end
    end else begin
      m_err = 1;
    end
  endtask

  task automatic wr_rec(input int r, input logic [7:0] hdr);
    wr_byte(hdr);
    for (int b = 1; b < REC; b++) wr_byte(raw_pat(r, b));
  endtask

  task automatic pulse_done();
    @(negedge clk);
    cfg_done = 1'b1;
    @(posedge clk);
    #1 cfg_done = 1'b0;
    m_lock = 1;
  endtask

  task automatic expect_lkp(input int idx, input string req);
    item_t it;
    it.idx = idx; it.req = req;
    it.vld = (idx < N_EP) ? m_vld[idx] : 1'b0;
    it.hdr = (idx < N_EP) ? m_mem[idx][0] : 8'h0;
    it.raw = '0;
    if (idx < N_EP)
      for (int b = 1; b < REC; b++) it.raw[(b-1)*8 +: 8] = m_mem[idx][b];
    q.push_back(it);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic check_status(input string req);
    @(negedge clk);
    check(req, "loaded_o", 32'(loaded), 32'(m_loaded));
    check(req, "locked_o", 32'(locked), 32'(m_lock));
    check(req, "err_o",    32'(err),    32'(m_err));
  endtask

  // monitor: pops expected lookups and compares
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        lkp_idx = 4'(it.idx);
        #1;
        check(it.req, $sformatf("valid[%0d]", it.idx), 32'(lkp_valid), 32'(it.vld));
        if (it.vld) begin
          check(it.req, $sformatf("ep[%0d]", it.idx),  32'(lkp_ep),  32'(it.hdr[7:4]));
          check(it.req, $sformatf("cfg[%0d]", it.idx), 32'(lkp_cfg), 32'(it.hdr[3:2]));
          check(it.req, $sformatf("if[%0d]", it.idx),  32'(lkp_if),  32'(it.hdr[1:0]));
          check(it.req, $sformatf("raw[%0d]", it.idx), lkp_raw, it.raw);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    model_clear();
    do_reset();
    // R8 reset state
    check_status("R8");
    for (int i = 0; i < 12; i++) expect_lkp(i, "R3");
    drain();

    // R3 partial record stays invalid
    wr_byte(hdr_pat(0));
    wr_byte(raw_pat(0, 1));
    wr_byte(raw_pat(0, 2));
    expect_lkp(0, "R3");
    drain();
    wr_byte(raw_pat(0, 3));
    wr_byte(raw_pat(0, 4));
    expect_lkp(0, "R1");
    drain();

    // R1 R2 fill the table; R4 not loaded before last byte
    for (int r = 1; r < N_EP - 1; r++) wr_rec(r, hdr_pat(r));
    check_status("R4");
    wr_rec(N_EP - 1, hdr_pat(N_EP - 1));
    check_status("R4");
    for (int i = 0; i < N_EP; i++) expect_lkp(i, "R2");
    expect_lkp(14, "R3");
    drain();

    // R5 write after lock ignored
    wr_byte(8'hFF);
    wr_byte(8'h12);
    check_status("R5");
    expect_lkp(0, "R5");
    expect_lkp(N_EP - 1, "R5");
    drain();

    // R8 reset clears contents
    do_reset();
    check_status("R8");
    expect_lkp(0, "R8");
    drain();

    // R7 early lock by done strobe
    wr_rec(0, 8'h35);
    wr_rec(1, 8'h26);
    pulse_done();
    check_status("R7");
    wr_rec(2, 8'h17);
    check_status("R7");
    expect_lkp(0, "R7");
    expect_lkp(1, "R7");
    expect_lkp(2, "R7");
    drain();

    // R6 bad endpoint number, alignment kept
    do_reset();
    wr_rec(0, 8'h51);
    check_status("R6");
    wr_rec(1, 8'h12);
    expect_lkp(0, "R6");
    expect_lkp(1, "R6");
    drain();

    // R6 bad configuration number
    do_reset();
    wr_rec(0, 8'h08);
    check_status("R6");
    wr_rec(1, 8'h27);
    expect_lkp(0, "R6");
    expect_lkp(1, "R6");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule